// File: doc/BRIEF.md
# Interrupt Trigger Configuration Register Bank

This block holds the per-interrupt trigger-mode settings of an interrupt distributor. It captures each interrupt input line into a pending bit according to that setting. Interrupt IDs fall into three classes. IDs 0-15 are software-generated and always edge-captured. IDs 16-31 are private to each processor and have their own input lines and pending bits per processor. IDs 32 and up are shared peripheral lines.

Software reaches the settings through a synchronous read/write port. Every interrupt owns a two-bit field. The upper bit selects edge (1) or level (0) capture, and the lower bit is reserved. A processor-select input on the port chooses which processor's copy of the private-ID word is accessed.

A small acknowledge port returns the lowest-numbered pending ID seen by the requesting processor. It clears that ID's pending bit when the ID is edge-captured.

The acknowledge sequencer has two states. `S_IDLE` waits. The transition `S_IDLE -> S_REPLY` is taken when `ack_req` is high: the result is registered and the chosen edge-pending bit is cleared. `S_REPLY` presents the result for one cycle. The transition `S_REPLY -> S_IDLE` is unconditional, and a request seen during `S_REPLY` is dropped.

Top module: `irq_trigger_bank`

## Requirements
- R1: Configuration word n sits at byte offset 0xC00 + 4n. Interrupt ID 16n+F uses bits [2F+1:2F] of that word, and bit 2F+1 is the trigger bit (1 = edge, 0 = level).
- R2: The lower bit (2F) of every field always reads 0, and writing 1 to it has no effect.
- R3: Word 0 (IDs 0-15) always reads 0xAAAAAAAA, and writes to it are ignored.
- R4: Trigger bits of shared IDs (words 2 and up) read back the last value written.
- R5: With writable private bits and more than one processor, word 1 is held per processor. `reg_cpu` selects the copy for both reads and writes.
- R6: After reset, every programmable trigger bit is 0. The shared words and word 1 of every processor therefore read 0.
- R7: An access whose offset is outside the implemented words, or not 4-byte aligned, reads 0 and changes nothing.
- R8: Read data appears on `reg_rdata` in the cycle after `reg_rd` is sampled high.
- R9: In edge mode, a 0-to-1 change of an input between two clocks sets a pending bit. The bit stays set after the input falls, until an acknowledge selects it.
- R10: In level mode, the pending bit equals the input as sampled on the previous clock, and acknowledge does not clear it.
- R11: For a request sampled on a clock edge, `ack_valid` is high for exactly the next cycle. `ack_id` then carries the lowest pending ID among the IDs 0-15, the private bank of `ack_cpu`, and the shared IDs.
- R12: When nothing is pending for the requester, `ack_id` is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 12 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_cpu | input | CPU_W | Processor issuing the access |
| reg_rdata | output | 32 | Registered read data |
| sgi_in | input | 16 | Lines for IDs 0-15 |
| ppi_in | input | NUM_CPU*16 | Private lines, processor c at bits [16c+15:16c] |
| spi_in | input | NUM_IRQ-32 | Shared lines, bit k is ID 32+k |
| ack_req | input | 1 | Acknowledge request |
| ack_cpu | input | CPU_W | Requesting processor |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged ID or 1023 |

## Verification
The hardest condition to reach is the interaction between the per-processor private banks and acknowledge. The private line of one processor can be pending while another processor asks. The stimulus therefore first programs different word-1 copies for two processors, then holds a private line of processor 1 high in level mode. Processor 0's acknowledge must then return 1023, while processor 1 receives the private ID twice because level-mode bits are not cleared. Priority ordering is reached by raising a low-numbered and a shared line in the same cycle and draining them with successive acknowledges.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;
    localparam int          WORD_BITS   = 32;
    localparam int          FIELDS      = 16;
    localparam int          ID_W        = 10;
    localparam logic [9:0]  BASE_WORD   = 10'h300;
    localparam logic [9:0]  SPURIOUS_ID = 10'd1023;
    localparam logic [31:0] ALL_EDGE    = 32'hAAAA_AAAA;
    localparam logic [31:0] RSVD_MASK   = 32'h5555_5555;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_REPLY = 1'b1
    } ack_state_e;

    function automatic logic [31:0] spread_modes(input logic [15:0] m);
        logic [31:0] w;
        w = '0;
        for (int f = 0; f < FIELDS; f++) begin
            w[2*f+1] = m[f];
        end
        return w;
    endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_trig_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,
    parameter int          NUM_CPU   = 2,
    parameter bit          PRIV_PROG = 1'b1,
    parameter logic [15:0] PPI_FIXED = 16'h0000,
    parameter int          CPU_W     = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [11:0]             reg_addr,
    input  logic [31:0]             reg_wdata,
    input  logic [CPU_W-1:0]        reg_cpu,
    output logic [31:0]             reg_rdata,
    output logic [NUM_CPU*16-1:0]   ppi_mode,
    output logic [NUM_IRQ-33:0]     spi_mode
);
    localparam int NWORDS  = NUM_IRQ / FIELDS;
    localparam int NUM_SPI = NUM_IRQ - 32;

    logic [9:0]  widx;
    logic        in_range;
    logic [15:0] ppi_sel;
    logic [15:0] spi_sel;
    logic [31:0] rd_word;

    assign widx     = reg_addr[11:2] - BASE_WORD;
    assign in_range = (reg_addr[11:2] >= BASE_WORD) &&
                      (widx < 10'(NWORDS)) && (reg_addr[1:0] == 2'b00);

    // Shared-ID trigger bits: always programmable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_mode <= '0;
        end else if (reg_wr && in_range) begin
            for (int k = 0; k < NUM_SPI; k++) begin
                if (widx == 10'(2 + k / FIELDS)) begin
                    spi_mode[k] <= reg_wdata[2*(k%FIELDS)+1];
                end
            end
        end
    end

    // Private-ID trigger bits: one bank per processor, or fixed
    generate
        if (PRIV_PROG) begin : g_priv_prog
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        ppi_mode[c*16 +: 16] <= '0;
                    end else if (reg_wr && in_range && widx == 10'd1 &&
                                 reg_cpu == CPU_W'(c)) begin
                        for (int f = 0; f < FIELDS; f++) begin
                            ppi_mode[c*16+f] <= reg_wdata[2*f+1];
                        end
                    end
                end
            end
        end else begin : g_priv_fixed
            for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
                assign ppi_mode[c*16 +: 16] = PPI_FIXED;
            end
        end
    endgenerate

    always_comb begin
        ppi_sel = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (reg_cpu == CPU_W'(c)) ppi_sel = ppi_mode[c*16 +: 16];
        end
        spi_sel = '0;
        for (int w = 2; w < NWORDS; w++) begin
            if (widx == 10'(w)) spi_sel = spi_mode[(w-2)*16 +: 16];
        end
        if (!in_range)            rd_word = '0;
        else if (widx == 10'd0)   rd_word = ALL_EDGE;
        else if (widx == 10'd1)   rd_word = spread_modes(ppi_sel);
        else                      rd_word = spread_modes(spi_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_word;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> ((reg_rdata & RSVD_MASK) == 32'h0)); // R2
    AST_SGI_RAO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 12'hC00) |=> (reg_rdata == ALL_EDGE)); // R3
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_in,
    input  logic [W-1:0] mode,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] prev;
    logic [W-1:0] rise;
    logic [W-1:0] pend_n;

    assign rise   = line_in & ~prev;
    assign pend_n = (mode & ((pend & ~clr) | rise)) | (~mode & line_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            pend <= '0;
        end else begin
            prev <= line_in;
            pend <= pend_n;
        end
    end

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(pend & mode & ~clr)) == $past(pend & mode & ~clr))); // R9
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(mode)) == ($past(line_in) & ~$past(mode)))); // R10
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_trig_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_req,
    input  logic [CPU_W-1:0]       ack_cpu,
    input  logic [15:0]            pend_sgi,
    input  logic [NUM_CPU*16-1:0]  pend_ppi,
    input  logic [NUM_IRQ-33:0]    pend_spi,
    output logic [15:0]            clr_sgi,
    output logic [NUM_CPU*16-1:0]  clr_ppi,
    output logic [NUM_IRQ-33:0]    clr_spi,
    output logic                   ack_valid,
    output logic [ID_W-1:0]        ack_id
);
    ack_state_e           state_q, state_d;
    logic [15:0]          ppi_view;
    logic [NUM_IRQ-1:0]   view;
    logic [NUM_IRQ-1:0]   pick;
    logic [ID_W-1:0]      low_id;
    logic                 found;
    logic                 take;

    always_comb begin
        ppi_view = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_cpu == CPU_W'(c)) ppi_view = pend_ppi[c*16 +: 16];
        end
        view = {pend_spi, ppi_view, pend_sgi};
    end

    // Lowest-numbered pending ID
    always_comb begin
        found  = 1'b0;
        low_id = SPURIOUS_ID;
        pick   = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (!found && view[i]) begin
                found   = 1'b1;
                low_id  = ID_W'(i);
                pick[i] = 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        ack_valid = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (ack_req) begin
                    take    = 1'b1;
                    state_d = S_REPLY;
                end
            end
            S_REPLY: begin
                ack_valid = 1'b1;
                state_d   = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
        clr_sgi = take ? pick[15:0] : '0;
        clr_spi = take ? pick[NUM_IRQ-1:32] : '0;
        clr_ppi = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (take && ack_cpu == CPU_W'(c)) clr_ppi[c*16 +: 16] = pick[31:16];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    ack_id <= SPURIOUS_ID;
        else if (take) ack_id <= low_id;
    end

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_spi, clr_ppi, clr_sgi})); // R11
    AST_REPLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R11
    AST_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && ack_req && view == '0) |=> (ack_id == SPURIOUS_ID)); // R12
endmodule

// File: rtl/irq_trigger_bank.sv
module irq_trigger_bank
    import irq_trig_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,
    parameter int          NUM_CPU   = 2,
    parameter bit          PRIV_PROG = 1'b1,
    parameter logic [15:0] PPI_FIXED = 16'h0000,
    localparam int         CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int         NUM_SPI   = NUM_IRQ - 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic                   reg_rd,
    input  logic [11:0]            reg_addr,
    input  logic [31:0]            reg_wdata,
    input  logic [CPU_W-1:0]       reg_cpu,
    output logic [31:0]            reg_rdata,
    input  logic [15:0]            sgi_in,
    input  logic [NUM_CPU*16-1:0]  ppi_in,
    input  logic [NUM_SPI-1:0]     spi_in,
    input  logic                   ack_req,
    input  logic [CPU_W-1:0]       ack_cpu,
    output logic                   ack_valid,
    output logic [9:0]             ack_id
);
    logic [NUM_CPU*16-1:0] ppi_mode, pend_ppi, clr_ppi;
    logic [NUM_SPI-1:0]    spi_mode, pend_spi, clr_spi;
    logic [15:0]           pend_sgi, clr_sgi;

    irq_cfg_regs #(
        .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIV_PROG(PRIV_PROG),
        .PPI_FIXED(PPI_FIXED), .CPU_W(CPU_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_cpu(reg_cpu),
        .reg_rdata(reg_rdata), .ppi_mode(ppi_mode), .spi_mode(spi_mode)
    );

    irq_edge_capture #(.W(16)) u_cap_sgi (
        .clk(clk), .rst_n(rst_n), .line_in(sgi_in), .mode(16'hFFFF),
        .clr(clr_sgi), .pend(pend_sgi)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_ppi
            irq_edge_capture #(.W(16)) u_cap_ppi (
                .clk(clk), .rst_n(rst_n), .line_in(ppi_in[c*16 +: 16]),
                .mode(ppi_mode[c*16 +: 16]), .clr(clr_ppi[c*16 +: 16]),
                .pend(pend_ppi[c*16 +: 16])
            );
        end
    endgenerate

    irq_edge_capture #(.W(NUM_SPI)) u_cap_spi (
        .clk(clk), .rst_n(rst_n), .line_in(spi_in), .mode(spi_mode),
        .clr(clr_spi), .pend(pend_spi)
    );

    irq_ack_fsm #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_cpu(ack_cpu),
        .pend_sgi(pend_sgi), .pend_ppi(pend_ppi), .pend_spi(pend_spi),
        .clr_sgi(clr_sgi), .clr_ppi(clr_ppi), .clr_spi(clr_spi),
        .ack_valid(ack_valid), .ack_id(ack_id)
    );
endmodule

// File: tb/irq_trigger_bank_bench.sv
`timescale 1ns/1ps
module irq_trigger_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [0:0]  reg_cpu = '0;
    logic [31:0] reg_rdata;
    logic [15:0] sgi_in = '0;
    logic [31:0] ppi_in = '0;
    logic [31:0] spi_in = '0;
    logic        ack_req = 1'b0;
    logic [0:0]  ack_cpu = '0;
    logic        ack_valid;
    logic [9:0]  ack_id;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    irq_trigger_bank u_irq_trigger_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_cpu(reg_cpu),
        .reg_rdata(reg_rdata), .sgi_in(sgi_in), .ppi_in(ppi_in),
        .spi_in(spi_in), .ack_req(ack_req), .ack_cpu(ack_cpu),
        .ack_valid(ack_valid), .ack_id(ack_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit cpu);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_cpu = cpu;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [11:0] a, input bit cpu,
                            input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_cpu = cpu;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, reg_rdata, exp);   // R8: one cycle after the strobe
    endtask

    task automatic ack_check(input bit cpu, input int exp, input string req);
        @(negedge clk);
        ack_req = 1'b1; ack_cpu = cpu;
        @(negedge clk);
        ack_req = 1'b0;
        check({req, " valid"}, {31'h0, ack_valid}, 32'h1);
        check(req, {22'h0, ack_id}, exp);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check(12'hC00, 1'b0, 32'hAAAA_AAAA, "R6 word0");
        rd_check(12'hC04, 1'b0, 32'h0, "R6 word1 cpu0");
        rd_check(12'hC04, 1'b1, 32'h0, "R6 word1 cpu1");
        rd_check(12'hC08, 1'b0, 32'h0, "R6 word2");
        rd_check(12'hC0C, 1'b0, 32'h0, "R6 word3");
        ack_check(1'b0, 1023, "R12 spurious after reset");
    endtask

    task automatic t_fields();
        wr(12'hC08, 32'hFFFF_FFFF, 1'b0);
        rd_check(12'hC08, 1'b0, 32'hAAAA_AAAA, "R2 R4 word2 all ones");
        wr(12'hC0C, 32'h5555_5555, 1'b0);
        rd_check(12'hC0C, 1'b0, 32'h0, "R2 reserved write ignored");
        wr(12'hC0C, 32'h0000_0200, 1'b0);
        rd_check(12'hC0C, 1'b0, 32'h0000_0200, "R1 ID52 field position");
        wr(12'hC0C, 32'h0, 1'b0);
        wr(12'hC00, 32'h0, 1'b0);
        rd_check(12'hC00, 1'b0, 32'hAAAA_AAAA, "R3 word0 write ignored");
    endtask

    task automatic t_bank();
        wr(12'hC04, 32'hAAAA_0000, 1'b0);
        wr(12'hC04, 32'h0000_000A, 1'b1);
        rd_check(12'hC04, 1'b0, 32'hAAAA_0000, "R5 cpu0 copy");
        rd_check(12'hC04, 1'b1, 32'h0000_000A, "R5 cpu1 copy");
    endtask

    task automatic t_range();
        wr(12'hC10, 32'hFFFF_FFFF, 1'b0);
        rd_check(12'hC10, 1'b0, 32'h0, "R7 beyond last word");
        rd_check(12'h000, 1'b0, 32'h0, "R7 below base");
        wr(12'hC0E, 32'hFFFF_FFFF, 1'b0);
        rd_check(12'hC0E, 1'b0, 32'h0, "R7 unaligned read");
        rd_check(12'hC0C, 1'b0, 32'h0, "R7 unaligned write ignored");
    endtask

    task automatic t_edge();
        @(negedge clk); spi_in[3] = 1'b1;
        @(negedge clk); spi_in[3] = 1'b0;
        @(negedge clk); @(negedge clk);
        ack_check(1'b0, 35, "R9 R11 edge held after input fell");
        ack_check(1'b0, 1023, "R9 edge cleared by ack");
    endtask

    task automatic t_level();
        @(negedge clk); spi_in[20] = 1'b1;
        @(negedge clk); @(negedge clk);
        ack_check(1'b0, 52, "R10 level pending");
        ack_check(1'b0, 52, "R10 level not cleared by ack");
        spi_in[20] = 1'b0;
        @(negedge clk); @(negedge clk);
        ack_check(1'b0, 1023, "R10 level drops with input");
    endtask

    task automatic t_prio();
        @(negedge clk); sgi_in[5] = 1'b1; spi_in[0] = 1'b1;
        @(negedge clk); sgi_in[5] = 1'b0; spi_in[0] = 1'b0;
        @(negedge clk);
        ack_check(1'b0, 5, "R11 lowest first");
        ack_check(1'b0, 32, "R11 next pending");
        ack_check(1'b0, 1023, "R12 drained");
    endtask

    task automatic t_private();
        @(negedge clk); ppi_in[18] = 1'b1;
        @(negedge clk); @(negedge clk);
        ack_check(1'b0, 1023, "R11 other cpu bank not seen");
        ack_check(1'b1, 18, "R11 private ID for cpu1");
        ack_check(1'b1, 18, "R10 private level stays");
        ppi_in[18] = 1'b0;
        @(negedge clk); @(negedge clk);
        ack_check(1'b1, 1023, "R12 private drained");
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_bank();
        t_range();
        t_edge();
        t_level();
        t_prio();
        t_private();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule